// File: doc/BRIEF.md
# ADC Peak Level Capture Register

This block watches a stream of signed converter samples and keeps the largest magnitude seen while capture is enabled. The held magnitude is always presented as a 6-bit attenuation code in 1 dB steps below full scale. Code 0 means the peak reached full scale. Code 63 means the peak sits at or below the -63 dB level, or that nothing has been captured yet.

A register interface reads the code with a one-cycle read strobe. The read returns the code held before the strobe, and the register then clears itself, so the next read covers only the interval after this one. Capture is gated by an enable level. Dropping the enable freezes the held value. Raising it again starts a fresh capture from zero.

Control is a two-state machine. `PK_IDLE` means capture is off and the held value is frozen. `PK_TRACK` means capture is running. The transition `arm` (`PK_IDLE` to `PK_TRACK`) is taken in any cycle where the enable is high while idle, and it restarts the held value from zero. The transition `disarm` (`PK_TRACK` to `PK_IDLE`) is taken in any cycle where the enable is low while tracking. A read clears the held value in either state.

Top module: `peak_level_capture`

## Requirements
- R1: After reset the machine is in `PK_IDLE`, the held magnitude is zero and the code output is 63.
- R2: The magnitude of a sample is its absolute value taken as two's complement. The most negative input saturates to full scale FS = 2^(W-1)-1, so both FS and -2^(W-1) give code 0.
- R3: The code output is the smallest n in 0..63 for which the held magnitude is at least FS x 10^(-n/20). With W = 24, a magnitude equal to ceil(FS/10) gives code 20, and one less gives code 21.
- R4: A held magnitude that is below the n = 63 threshold, including zero, gives code 63.
- R5: While enabled, the block holds the largest magnitude among valid samples. A later smaller sample does not lower the held value, and a later larger sample raises it.
- R6: While the enable input is low, valid samples are ignored and the held value and code stay frozen. A read still clears them.
- R7: When the enable is raised from `PK_IDLE`, capture restarts from zero. A valid sample in that same cycle is the first one counted.
- R8: During the cycle where the read strobe is high, the code output still shows the value held before the read. From the next cycle it shows 63, unless R9 applies.
- R9: A read that coincides with a valid sample while enabled clears the old peak. The held value is then exactly that new sample's magnitude, even when it is smaller than the old peak.
- R10: A sample whose valid strobe is low has no effect on the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | W | Signed two's complement converter sample |
| sample_vld_i | input | 1 | Qualifies sample_i for one cycle |
| enable_i | input | 1 | Capture enable level |
| rd_i | input | 1 | One-cycle read strobe; clears the held peak after this cycle |
| peak_code_o | output | 6 | Peak attenuation below full scale, 0..63 dB |

## Verification
The magnitude path is driven with positive full scale, the most negative code and ordinary negative values. This separates a correct absolute value and saturation from a plain sign drop or an off-by-one negate. Magnitudes placed exactly on a threshold and one step below it, together with zero and sub-threshold levels, pin down the comparison direction and the fallback code. Rising-then-falling sample sequences show peak holding as distinct from following the latest sample. Toggling the enable, dropping the valid strobe and reading with and without a coincident sample tell freezing, restarting and clear-on-read apart, because each of them leaves a different code afterwards.

// File: rtl/peak_level_pkg.sv
package peak_level_pkg;

    typedef enum logic [0:0] {
        PK_IDLE  = 1'b0,
        PK_TRACK = 1'b1
    } pk_state_e;

    localparam int PK_CODE_W  = 6;
    localparam int PK_N_STEPS = 64;

    // Smallest integer magnitude that meets fs * 10^(-n/20)
    function automatic longint pk_thresh(input longint fs, input int n);
        real lvl;
        lvl = real'(fs) * (10.0 ** (-real'(n) / 20.0));
        return longint'($ceil(lvl));
    endfunction

endpackage

// File: rtl/peak_mag.sv
module peak_mag #(
    parameter int W = 24,
    localparam int MW = W - 1
) (
    input  logic [W-1:0]  sample_i,
    output logic [MW-1:0] mag_o
);

    always_comb begin
        if (!sample_i[W-1]) begin
            mag_o = sample_i[MW-1:0];
        end else if (sample_i[MW-1:0] == '0) begin
            mag_o = '1;                       // most negative saturates
        end else begin
            mag_o = (~sample_i[MW-1:0]) + 1'b1;
        end
    end

    always_comb begin
        if (sample_i[W-1] && sample_i != {1'b1, {MW{1'b0}}}) begin
            a_r2_neg_mag: assert (mag_o != '0);
        end
    end

endmodule

// File: rtl/peak_db_encode.sv
module peak_db_encode
    import peak_level_pkg::*;
#(
    parameter int W = 24,
    localparam int MW = W - 1,
    localparam longint FS = (64'sd1 <<< MW) - 64'sd1
) (
    input  logic [MW-1:0]          mag_i,
    output logic [PK_CODE_W-1:0]   code_o
);

    logic [PK_N_STEPS-1:0] hit;

    for (genvar gi = 0; gi < PK_N_STEPS; gi++) begin : g_step
        localparam logic [MW-1:0] THR = MW'(pk_thresh(FS, gi));
        assign hit[gi] = (mag_i >= THR);
    end

    always_comb begin
        code_o = PK_CODE_W'(PK_N_STEPS - 1);
        for (int n = PK_N_STEPS - 1; n >= 0; n--) begin
            if (hit[n]) code_o = PK_CODE_W'(n);
        end
    end

    always_comb begin
        if (mag_i == '0) begin
            a_r4_zero_floor: assert (code_o == PK_CODE_W'(PK_N_STEPS - 1));
        end
        if (mag_i == '1) begin
            a_r3_full_scale: assert (code_o == '0);
        end
    end

endmodule

// File: rtl/peak_hold_ctrl.sv
module peak_hold_ctrl
    import peak_level_pkg::*;
#(
    parameter int MW = 23
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [MW-1:0] mag_i,
    input  logic          sample_vld_i,
    input  logic          enable_i,
    input  logic          rd_i,
    output logic [MW-1:0] held_o
);

    pk_state_e     state_q, state_d;
    logic [MW-1:0] held_q, held_d, base;
    logic          restart, take;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PK_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // next state and held value
    always_comb begin
        state_d = state_q;
        restart = rd_i;
        unique case (state_q)
            PK_IDLE: begin
                if (enable_i) begin
                    state_d = PK_TRACK;      // arm
                    restart = 1'b1;
                end
            end
            PK_TRACK: begin
                if (!enable_i) state_d = PK_IDLE;  // disarm
            end
            default: state_d = PK_IDLE;
        endcase
        take   = sample_vld_i && enable_i;
        base   = restart ? '0 : held_q;
        held_d = base;
        if (take && (mag_i > base)) held_d = mag_i;
    end

    assign held_o = held_q;

    a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!enable_i && !rd_i) |=> $stable(held_q));

    a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !(sample_vld_i && enable_i)) |=> (held_q == '0));

    a_r9_read_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && sample_vld_i && enable_i) |=> (held_q == $past(mag_i)));

    a_r5_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PK_TRACK && enable_i && !rd_i) |=> (held_q >= $past(held_q)));

    a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PK_IDLE && enable_i && !sample_vld_i) |=> (held_q == '0));

    a_r10_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PK_TRACK && enable_i && !sample_vld_i && !rd_i) |=> $stable(held_q));

endmodule

// File: rtl/peak_level_capture.sv
module peak_level_capture
    import peak_level_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [W-1:0]         sample_i,
    input  logic                 sample_vld_i,
    input  logic                 enable_i,
    input  logic                 rd_i,
    output logic [PK_CODE_W-1:0] peak_code_o
);

    localparam int MW = W - 1;

    logic [MW-1:0] mag, held;

    peak_mag #(.W(W)) u_mag (
        .sample_i (sample_i),
        .mag_o    (mag)
    );

    peak_hold_ctrl #(.MW(MW)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mag_i        (mag),
        .sample_vld_i (sample_vld_i),
        .enable_i     (enable_i),
        .rd_i         (rd_i),
        .held_o       (held)
    );

    peak_db_encode #(.W(W)) u_enc (
        .mag_i  (held),
        .code_o (peak_code_o)
    );

endmodule

// File: tb/peak_level_capture_bench.sv
`timescale 1ns/1ps
module peak_level_capture_bench;

    localparam int W = 24;
    localparam longint FS = (64'sd1 <<< (W - 1)) - 64'sd1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] smp = '0;
    logic         vld = 1'b0;
    logic         en = 1'b0;
    logic         rd = 1'b0;
    logic [5:0]   code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    peak_level_capture #(.W(W)) u_peak_level_capture (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sample_i     (smp),
        .sample_vld_i (vld),
        .enable_i     (en),
        .rd_i         (rd),
        .peak_code_o  (code)
    );

    function automatic logic [W-1:0] sv(input longint v);
        return W'(v);
    endfunction

    function automatic longint bmag(input longint v);
        longint m;
        m = (v < 0) ? -v : v;
        if (m > FS) m = FS;
        return m;
    endfunction

    function automatic int bcode(input longint m);
        for (int n = 0; n < 64; n++) begin
            if (real'(m) >= real'(FS) * (10.0 ** (-real'(n) / 20.0))) return n;
        end
        return 63;
    endfunction

    task automatic chk(input int exp, input string req);
        checks++;
        if (code !== 6'(exp)) begin
            errors++;
            $display("FAIL %s: code=%0d expected=%0d", req, code, exp);
        end
    endtask

    // apply inputs for one cycle, look after the register update
    task automatic step(input logic v, input longint s, input logic e, input logic r);
        @(negedge clk);
        vld = v; smp = sv(s); en = e; rd = r;
        @(posedge clk);
        #1;
    endtask

    task automatic clear_read();
        step(1'b0, 0, en, 1'b1);
    endtask

    task automatic t_reset();
        chk(63, "R1 reset");
    endtask

    task automatic t_magnitude();
        step(1'b0, 0, 1'b1, 1'b0);
        step(1'b1, FS, 1'b1, 1'b0);
        chk(0, "R2 positive full scale");
        clear_read();
        step(1'b1, -(64'sd1 <<< (W - 1)), 1'b1, 1'b0);
        chk(0, "R2 most negative saturates");
        clear_read();
        step(1'b1, -1000000, 1'b1, 1'b0);
        chk(bcode(bmag(-1000000)), "R2 negative sample");
        clear_read();
    endtask

    task automatic t_thresholds();
        longint t20;
        t20 = longint'($ceil(real'(FS) / 10.0));
        step(1'b1, t20, 1'b1, 1'b0);
        chk(20, "R3 on threshold");
        clear_read();
        step(1'b1, t20 - 1, 1'b1, 1'b0);
        chk(21, "R3 below threshold");
        clear_read();
        step(1'b1, FS / 2, 1'b1, 1'b0);
        chk(bcode(FS / 2), "R3 half scale");
        clear_read();
        step(1'b1, 0, 1'b1, 1'b0);
        chk(63, "R4 zero sample");
        step(1'b1, 3000, 1'b1, 1'b0);
        chk(63, "R4 below floor");
        clear_read();
    endtask

    task automatic t_hold_max();
        step(1'b1, 1000000, 1'b1, 1'b0);
        step(1'b1, 200000, 1'b1, 1'b0);
        chk(bcode(1000000), "R5 smaller sample keeps peak");
        step(1'b1, -3000000, 1'b1, 1'b0);
        chk(bcode(3000000), "R5 larger sample raises peak");
        step(1'b0, FS, 1'b1, 1'b0);
        chk(bcode(3000000), "R10 invalid sample ignored");
    endtask

    task automatic t_disable();
        step(1'b1, FS, 1'b0, 1'b0);
        chk(bcode(3000000), "R6 disabled sample ignored");
        step(1'b1, -FS, 1'b0, 1'b0);
        chk(bcode(3000000), "R6 value frozen");
        step(1'b0, 0, 1'b1, 1'b0);
        chk(63, "R7 enable restarts from zero");
        step(1'b1, 500000, 1'b1, 1'b0);
        chk(bcode(500000), "R7 first sample after restart");
        step(1'b0, 0, 1'b0, 1'b0);
        step(1'b1, 40000, 1'b1, 1'b0);
        chk(bcode(40000), "R7 sample in enabling cycle counted");
    endtask

    task automatic t_read();
        step(1'b1, 4000000, 1'b1, 1'b0);
        @(negedge clk);
        vld = 1'b0; rd = 1'b1;
        #1;
        chk(bcode(4000000), "R8 old value during read");
        @(posedge clk);
        #1;
        chk(63, "R8 cleared after read");
        step(1'b1, FS, 1'b0, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        step(1'b0, 0, 1'b1, 1'b0);
        step(1'b1, 2000000, 1'b1, 1'b0);
        step(1'b0, 0, 1'b0, 1'b1);
        chk(63, "R8 read while disabled clears");
    endtask

    task automatic t_read_with_sample();
        step(1'b1, FS, 1'b1, 1'b0);
        @(negedge clk);
        vld = 1'b1; smp = sv(100000); en = 1'b1; rd = 1'b1;
        #1;
        chk(0, "R9 read sees old peak");
        @(posedge clk);
        #1;
        chk(bcode(100000), "R9 restart from coincident sample");
        step(1'b0, 0, 1'b1, 1'b0);
        chk(bcode(100000), "R9 value kept after read");
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_magnitude();
        t_thresholds();
        t_hold_max();
        t_disable();
        t_read();
        t_read_with_sample();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule